// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block connects a clocked host to an external asynchronous static RAM of 262,144 words of 16 bits. The RAM has an active-low chip select, write strobe and output strobe, plus one active-low enable per byte lane. The host issues one request at a time. A request carries an address, write data, a per-lane byte mask and a read/write flag. The controller runs the strobe sequence for that request and then returns a one-cycle response pulse with the read data.

The controller counts wait states from a parameterised access time and clock period, so one design covers both the 55 ns and the 70 ns speed grades. It steers the byte-lane enables from the mask. It drives the data bus only while writing, and it adds a turnaround cycle when a write follows a read. When it is idle the memory is deselected, so the RAM stays in standby. A request whose mask has no lane set completes at once and touches no strobe.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, chip select, write strobe, output strobe and both lane enables are high, the data bus is released, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A read holds chip select and output strobe low, with the write strobe high, for exactly WAIT_CYC cycles. The next cycle has `rsp_valid` high for one cycle with chip select high.
- R3: A write has one setup cycle with chip select low, the write strobe high and the bus driven. Then the write strobe is low for WAIT_CYC cycles. Then comes one hold cycle with the write strobe high and the bus still driven, then one response cycle with the bus released.
- R4: Address, lane enables and write data do not change while the write strobe is low.
- R5: The data bus is driven only in the write setup, strobe and hold cycles, and never while the output strobe is low.
- R6: A write accepted after a completed read first spends one cycle with every strobe high and the bus released. A write after a write, or after an empty-mask request that itself followed a write, has no such cycle.
- R7: During an access, lane enable bit 0 (data bits 7:0) is low exactly when mask bit 0 is 1, and lane enable bit 1 (data bits 15:8) is low exactly when mask bit 1 is 1. Both are high whenever chip select is high.
- R8: A request with mask 2'b00 gives `rsp_valid` in the cycle after acceptance. No strobe goes low and memory contents are unchanged.
- R9: Read data lanes whose mask bit is 0 are returned as zero.
- R10: WAIT_CYC equals ceil(ACCESS_NS / CLK_NS) + 1. The defaults of 70 ns and 10 ns give 8.
- R11: A masked write changes only the enabled byte lanes of the addressed word. This is visible on read-back.
- R12: `req_ready` is high only while the controller is idle, and a request is accepted only when `req_valid` and `req_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte lanes to access, bit 0 = bits 7:0 |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output strobe, active low |
| mem_lane_n | output | 2 | Byte-lane enables, active low, bit 0 = low byte |
| mem_addr | output | 18 | Memory address |
| mem_dq_out | output | 16 | Data toward memory |
| mem_dq_oe | output | 1 | Tri-state control: 1 = controller drives the bus |
| mem_dq_in | input | 16 | Data from memory |

## Verification
The bench checks the read-then-write turnaround in both directions. A missing idle cycle would show the bus driven one cycle after the memory's outputs were on. A spurious idle cycle would shift every strobe of a write that follows another write. Empty-mask requests are placed between a read and a write: a design that strobed the memory would corrupt the word, and one that cleared the read history would drop the turnaround. Partial-lane writes and reads at the top address expose lane enables that are swapped or always on, and read lanes that are not masked to zero. The memory model flags a bus driven while the memory drives it, and any change of address or data under a low write strobe.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_TURN,
      ST_WSETUP,
      ST_WPULSE,
      ST_WHOLD,
      ST_READ,
      ST_DONE
   } ctl_state_e;

   function automatic int wait_cycles(input int access_ns, input int clk_ns);
      return (access_ns + clk_ns - 1) / clk_ns + 1;
   endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
   parameter int CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic last
);
   localparam int CW = $clog2(CYCLES + 1);

   logic [CW-1:0] cnt;

   if (CYCLES < 1) begin : g_bad_cycles
      $error("sram_wait_timer: CYCLES must be at least 1");
   end

   assign last = run && (cnt == CW'(CYCLES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt <= '0;
      else if (!run)      cnt <= '0;
      else if (last)      cnt <= '0;
      else                cnt <= cnt + 1'b1;
   end

   // R10
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(CYCLES - 1));

endmodule

// File: rtl/sram_lane_steer.sv
module sram_lane_steer #(
   parameter int LANES = 2
) (
   input  logic [LANES-1:0]   mask,
   input  logic               sel,
   input  logic [LANES*8-1:0] rd_raw,
   output logic [LANES-1:0]   lane_n,
   output logic [LANES*8-1:0] rd_clean
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_n[g]          = !(sel && mask[g]);
      assign rd_clean[g*8 +: 8] = mask[g] ? rd_raw[g*8 +: 8] : 8'h00;
   end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
   import sram_lane_pkg::*;
#(
   parameter int ADDR_W    = 18,
   parameter int LANES     = 2,
   parameter int CLK_NS    = 10,
   parameter int ACCESS_NS = 70
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic                 req_write,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [LANES*8-1:0]   req_wdata,
   input  logic [LANES-1:0]     req_mask,
   output logic                 rsp_valid,
   output logic [LANES*8-1:0]   rsp_rdata,
   output logic                 mem_ce_n,
   output logic                 mem_we_n,
   output logic                 mem_oe_n,
   output logic [LANES-1:0]     mem_lane_n,
   output logic [ADDR_W-1:0]    mem_addr,
   output logic [LANES*8-1:0]   mem_dq_out,
   output logic                 mem_dq_oe,
   input  logic [LANES*8-1:0]   mem_dq_in
);
   localparam int DATA_W   = LANES * 8;
   localparam int WAIT_CYC = wait_cycles(ACCESS_NS, CLK_NS);

   if (ADDR_W < 1 || LANES < 1) begin : g_bad_shape
      $error("sram_lane_ctrl: ADDR_W and LANES must be positive");
   end
   if (CLK_NS < 1 || ACCESS_NS < 1) begin : g_bad_timing
      $error("sram_lane_ctrl: CLK_NS and ACCESS_NS must be positive");
   end

   ctl_state_e             state, state_nx;
   logic                   after_read;
   logic [ADDR_W-1:0]      addr_q;
   logic [DATA_W-1:0]      wdata_q;
   logic [LANES-1:0]       mask_q;
   logic [DATA_W-1:0]      rdata_q;
   logic [DATA_W-1:0]      rd_clean;
   logic                   accept;
   logic                   selected;
   logic                   tmr_run;
   logic                   tmr_last;

   assign accept   = req_valid && (state == ST_IDLE);
   assign selected = (state == ST_WSETUP) || (state == ST_WPULSE) ||
                     (state == ST_WHOLD)  || (state == ST_READ);
   assign tmr_run  = (state == ST_WPULSE) || (state == ST_READ);

   sram_wait_timer #(.CYCLES(WAIT_CYC)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (tmr_run),
      .last  (tmr_last)
   );

   sram_lane_steer #(.LANES(LANES)) u_steer (
      .mask     (mask_q),
      .sel      (selected),
      .rd_raw   (mem_dq_in),
      .lane_n   (mem_lane_n),
      .rd_clean (rd_clean)
   );

   always_comb begin
      state_nx = state;
      case (state)
         ST_IDLE:
            if (accept) begin
               if (req_mask == '0)      state_nx = ST_DONE;
               else if (!req_write)     state_nx = ST_READ;
               else if (after_read)     state_nx = ST_TURN;
               else                     state_nx = ST_WSETUP;
            end
         ST_TURN:   state_nx = ST_WSETUP;
         ST_WSETUP: state_nx = ST_WPULSE;
         ST_WPULSE: if (tmr_last) state_nx = ST_WHOLD;
         ST_WHOLD:  state_nx = ST_DONE;
         ST_READ:   if (tmr_last) state_nx = ST_DONE;
         ST_DONE:   state_nx = ST_IDLE;
         default:   state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         after_read <= 1'b0;
         addr_q     <= '0;
         wdata_q    <= '0;
         mask_q     <= '0;
         rdata_q    <= '0;
      end else begin
         state <= state_nx;
         if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            mask_q  <= req_mask;
         end
         if (state == ST_READ && tmr_last) begin
            rdata_q    <= rd_clean;
            after_read <= 1'b1;
         end else if (state == ST_WHOLD) begin
            after_read <= 1'b0;
         end
      end
   end

   assign req_ready  = (state == ST_IDLE);
   assign rsp_valid  = (state == ST_DONE);
   assign rsp_rdata  = rdata_q;
   assign mem_ce_n   = !selected;
   assign mem_we_n   = !(state == ST_WPULSE);
   assign mem_oe_n   = !(state == ST_READ);
   assign mem_dq_oe  = (state == ST_WSETUP) || (state == ST_WPULSE) || (state == ST_WHOLD);
   assign mem_addr   = addr_q;
   assign mem_dq_out = wdata_q;

   // R5
   bus_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n);

   // R4
   we_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we_n && $past(!mem_we_n)) |->
         ($stable(mem_addr) && $stable(mem_dq_out) && $stable(mem_lane_n)));

   // R3
   release_after_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_dq_oe) |-> (mem_we_n && $past(mem_we_n)));

   // R7
   idle_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_ce_n |-> (&mem_lane_n));

   // R12
   ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_ce_n && !mem_dq_oe));

   // R8
   empty_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && (req_mask == '0)) |=> (rsp_valid && mem_ce_n));

endmodule

// File: tb/sram_lane_ctrl_test.sv
module sram_lane_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int ACC_NS     = 70;
   localparam int WAITS      = (ACC_NS + CLK_PERIOD - 1) / CLK_PERIOD + 1; // R10

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [17:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [1:0]  req_mask = '0;
   logic        rsp_valid;
   logic [15:0] rsp_rdata;
   logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [1:0]  mem_lane_n;
   logic [17:0] mem_addr;
   logic [15:0] mem_dq_out;
   logic [15:0] mem_dq_in = 16'hEEEE;

   int checks = 0;
   int fails  = 0;

   logic [7:0]  exp_vec[$];
   string       exp_tag[$];
   logic [16:0] exp_dat[$];
   logic [15:0] shadow[logic [17:0]];
   logic [15:0] cells[logic [17:0]];
   bit          prev_read = 0;
   logic        wl_prev = 1'b0;
   logic [17:0] wl_addr;
   logic [15:0] wl_data;
   logic [1:0]  wl_lane;

   always #(CLK_PERIOD/2) clk = ~clk;

   sram_lane_ctrl #(.CLK_NS(CLK_PERIOD), .ACCESS_NS(ACC_NS)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
      .mem_lane_n(mem_lane_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
      .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

   function automatic logic [15:0] peek(input logic [17:0] a, input bit sh);
      if (sh) return shadow.exists(a) ? shadow[a] : 16'h0000;
      return cells.exists(a) ? cells[a] : 16'h0000;
   endfunction

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // fields: ready, rsp_valid, ce_n, we_n, oe_n, dq_oe, lane_n[1:0]
   task automatic tick();
      logic [7:0] act, exp;
      string tag;
      logic [16:0] dat;
      @(negedge clk);
      act = {req_ready, rsp_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, mem_lane_n};
      if (exp_vec.size() > 0) begin
         exp = exp_vec.pop_front(); tag = exp_tag.pop_front(); dat = exp_dat.pop_front();
      end else begin
         exp = 8'b1011_1011; tag = "R12 idle"; dat = '0;
      end
      check(act == exp, tag, {24'h0, act}, {24'h0, exp});
      if (dat[16]) check(rsp_rdata == dat[15:0], "R9 R11 read data", {16'h0, rsp_rdata}, {16'h0, dat[15:0]});
      // memory model: truth table enforcement
      if (mem_dq_oe && !mem_ce_n && !mem_oe_n)
         check(0, "R5 bus contention", {31'h0, mem_dq_oe}, 32'h0);
      if (!mem_ce_n && (&mem_lane_n))
         check(0, "R7 select without lane", {30'h0, mem_lane_n}, 32'h0);
      if (!mem_we_n && !mem_dq_oe)
         check(0, "R3 write strobe without bus", 32'h0, 32'h1);
      if (!mem_we_n && wl_prev)
         if (mem_addr != wl_addr || mem_dq_out != wl_data || mem_lane_n != wl_lane)
            check(0, "R4 change under write strobe", {14'h0, mem_addr}, {14'h0, wl_addr});
      if (wl_prev && mem_we_n && !mem_ce_n) begin
         logic [15:0] v;
         v = peek(wl_addr, 0);
         if (!wl_lane[0]) v[7:0]  = wl_data[7:0];
         if (!wl_lane[1]) v[15:8] = wl_data[15:8];
         cells[wl_addr] = v;
      end
      wl_prev = !mem_we_n;
      wl_addr = mem_addr; wl_data = mem_dq_out; wl_lane = mem_lane_n;
      begin
         logic [15:0] r;
         r = peek(mem_addr, 0);
         mem_dq_in = 16'hEEEE;
         if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
            if (!mem_lane_n[0]) mem_dq_in[7:0]  = r[7:0];
            if (!mem_lane_n[1]) mem_dq_in[15:8] = r[15:8];
         end
      end
   endtask

   task automatic expect_v(input logic [7:0] v, input string tag, input logic [16:0] d);
      exp_vec.push_back(v); exp_tag.push_back(tag); exp_dat.push_back(d);
   endtask

   task automatic op(input bit wr, input logic [17:0] a, input logic [15:0] d, input logic [1:0] m);
      logic [1:0] ln;
      ln = ~m;
      while (!req_ready) tick();
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
      if (m == 2'b00) begin
         expect_v(8'b0111_1011, "R8 empty mask", '0);
      end else if (wr) begin
         logic [15:0] v;
         if (prev_read) expect_v(8'b0011_1011, "R6 turnaround", '0);
         expect_v({6'b000111, ln}, "R3 write setup", '0);
         for (int i = 0; i < WAITS; i++) expect_v({6'b000011, ln}, "R3 R10 write strobe", '0);
         expect_v({6'b000111, ln}, "R3 write hold", '0);
         expect_v(8'b0111_1011, "R3 write done", '0);
         v = peek(a, 1);
         if (m[0]) v[7:0]  = d[7:0];
         if (m[1]) v[15:8] = d[15:8];
         shadow[a] = v;
         prev_read = 0;
      end else begin
         logic [15:0] e;
         e = peek(a, 1);
         if (!m[0]) e[7:0]  = 8'h00;
         if (!m[1]) e[15:8] = 8'h00;
         for (int i = 0; i < WAITS; i++) expect_v({6'b000100, ln}, "R2 R7 R10 read strobe", '0);
         expect_v(8'b0111_1011, "R2 read done", {1'b1, e});
         prev_read = 1;
      end
      tick();
      req_valid = 1'b0;
      while (exp_vec.size() > 0) tick();
      tick();
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      check(0, "watchdog", 32'h0, 32'h1);
      summary();
   end

   initial begin
      tick();
      check({req_ready, rsp_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, mem_lane_n} == 8'b1011_1011,
            "R1 reset state", 32'h0, 32'hBB);
      tick();
      rst_n = 1'b1;
      tick();
      op(1, 18'h00005, 16'h1234, 2'b11);
      op(1, 18'h00006, 16'h5566, 2'b11);          // write after write, no R6 gap
      op(0, 18'h00005, 16'h0000, 2'b11);
      op(1, 18'h00005, 16'hAB77, 2'b01);          // R11 low lane only, after read
      op(0, 18'h00005, 16'h0000, 2'b10);          // R9 low lane zeroed
      op(0, 18'h00005, 16'h0000, 2'b01);
      op(1, 18'h00005, 16'hFFFF, 2'b00);          // R8 between read and write
      op(1, 18'h3FFFF, 16'hCD99, 2'b10);          // R6 still due, top address
      op(0, 18'h00005, 16'h0000, 2'b11);          // R8 left word intact
      op(0, 18'h3FFFF, 16'h0000, 2'b11);
      op(0, 18'h00006, 16'h0000, 2'b00);          // R8 read form
      for (int i = 0; i < 6; i++) begin
         op(1, 18'h20000 + 18'(i * 7), 16'h3C00 + 16'(i * 16'h0111), 2'(i % 3 + 1));
         op(0, 18'h20000 + 18'(i * 7), 16'h0000, 2'b11);
      end
      check(peek(18'h00005, 0) == 16'h1277, "R11 stored word", {16'h0, peek(18'h00005, 0)}, 32'h1277);
      summary();
   end
endmodule